// File: doc/BRIEF.md
# Prescaled 8-bit Backlight PWM Generator

This block is a single-channel pulse-width generator for driving a backlight. Each output period is 256 steps of a prescaled tick. An 8-bit compare value sets how many of those steps carry the active level. The counting source is either a slow tick or a system tick, chosen by one select input. Both sources arrive as single-cycle tick enables in the `clk` domain. A power-of-two prescaler stretches every step to 1 to 64 source ticks.

Software controls the block through a small register port. It has a configuration word and two separate write-one strobes, one to start the generator and one to stop it. A status flag shows whether the generator is really running. The flag rises on the first prescaled tick after a start request. It falls only when the period in progress has completed after a stop request. Configuration changes made while the generator runs are held back until the next period boundary, so no shortened or stretched pulse reaches the pin.

Top module: `bkl_pwm`

## Requirements
- R1: The configuration word at address 0 stores the compare value in bits 15:8, the polarity bit in bit 4 and the prescaler code in bits 2:0. A read of address 0 returns these fields with every other bit zero.
- R2: A configuration write whose prescaler code is 7 is rejected as a whole, and the stored word keeps its previous value.
- R3: While running, one period lasts 256 x 2^code ticks of the selected source. The active level is held for compare x 2^code of those ticks, starting at the period boundary.
- R4: With the select input at 1 the system tick drives the count. With it at 0 the slow tick drives the count and the system tick is ignored.
- R5: With the polarity bit at 1 the active level is high. With it at 0 the active level is low, and the inactive level is always the opposite of the active level.
- R6: A compare value of 0 holds the inactive level for the whole period, and a compare value of 255 gives 255 active steps out of 256.
- R7: Writing a word with bit 0 set to address 1 requests a start. The status flag (address 3, bit 0) rises on the first prescaled tick after the request, which is 2^code source ticks later.
- R8: Writing a word with bit 0 set to address 2 requests a stop. The status flag stays 1 until the last step of the current period has ended, then falls together with the output returning to its inactive level.
- R9: Writing a word with bit 0 clear to the start or the stop address has no effect on the running state.
- R10: A configuration write made during a period changes nothing in that period. The new compare value, polarity and prescaler take effect from the next period boundary.
- R11: While stopped, the output holds the inactive level of the stored polarity, and the step counter rests at zero.
- R12: After reset the generator is stopped, the configuration word reads 0, and the output is high (the inactive level for polarity 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| slow_tick | input | 1 | Slow counting source, one-cycle tick enable |
| sys_tick | input | 1 | System counting source, one-cycle tick enable |
| src_sel | input | 1 | Source select: 1 = system tick, 0 = slow tick |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 config, 1 start, 2 stop, 3 status |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr`, combinational |
| pwm_out | output | 1 | PWM output pin |

## Verification
If the step counter or the prescale divider holds a wrong value, the active-time count taken over one full period is off. This shows within one period, which is at most 16,384 source ticks with the default parameters. A wrong run or stop-pending state shows up at the status bit: either the flag changes before the exact cycle where the period boundary falls, or it misses that cycle. A register copy that is loaded at the wrong moment shows as a period with the old and new compare values mixed, and this is visible in the first period after the write. A fault in the configuration store shows at once in a read of address 0.

// File: rtl/bkl_pwm_pkg.sv
package bkl_pwm_pkg;
   // Field positions inside the configuration word (software visible)
   localparam int unsigned CODE_LSB = 0;
   localparam int unsigned POL_BIT  = 4;
   localparam int unsigned CMP_LSB  = 8;
   // Bit that carries the request / status in the strobe and status words
   localparam int unsigned RUN_BIT  = 0;

   typedef enum logic [1:0] {
      RA_CFG   = 2'd0,
      RA_START = 2'd1,
      RA_STOP  = 2'd2,
      RA_STAT  = 2'd3
   } reg_addr_e;
endpackage

// File: rtl/bkl_pwm_regs.sv
module bkl_pwm_regs
   import bkl_pwm_pkg::*;
#(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned CNT_W  = 8,
   parameter int unsigned PS_W   = 3,
   parameter int unsigned PS_MAX = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [1:0]        addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              run_i,
   output logic [CNT_W-1:0]  cfg_cmp,
   output logic              cfg_pol,
   output logic [PS_W-1:0]   cfg_code,
   output logic              start_req,
   output logic              stop_req,
   output logic [DATA_W-1:0] rdata
);
   reg_addr_e          sel;
   logic [CNT_W-1:0]   w_cmp;
   logic               w_pol;
   logic [PS_W-1:0]    w_code;
   logic               code_ok;
   logic               wdata_unused;

   assign sel          = reg_addr_e'(addr);
   assign w_cmp        = wdata[CMP_LSB +: CNT_W];
   assign w_pol        = wdata[POL_BIT];
   assign w_code       = wdata[CODE_LSB +: PS_W];
   assign code_ok      = (w_code <= PS_W'(PS_MAX));
   assign wdata_unused = ^wdata;

   // Configuration store: a write with an out-of-range code is dropped whole
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_cmp  <= '0;
         cfg_pol  <= 1'b0;
         cfg_code <= '0;
      end else if (wr && sel == RA_CFG && code_ok) begin
         cfg_cmp  <= w_cmp;
         cfg_pol  <= w_pol;
         cfg_code <= w_code;
      end
   end

   assign start_req = wr && (sel == RA_START) && wdata[RUN_BIT];
   assign stop_req  = wr && (sel == RA_STOP)  && wdata[RUN_BIT];

   always_comb begin
      rdata = '0;
      case (sel)
         RA_CFG: begin
            rdata[CMP_LSB +: CNT_W] = cfg_cmp;
            rdata[POL_BIT]          = cfg_pol;
            rdata[CODE_LSB +: PS_W] = cfg_code;
         end
         RA_STAT: rdata[RUN_BIT] = run_i;
         default: rdata = '0;
      endcase
   end
endmodule

// File: rtl/bkl_pwm_prescale.sv
module bkl_pwm_prescale #(
   parameter int unsigned PS_W   = 3,
   parameter int unsigned PS_MAX = 6
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            slow_tick,
   input  logic            sys_tick,
   input  logic            src_sel,
   input  logic            active,
   input  logic [PS_W-1:0] code,
   output logic            pres_tick
);
   logic src_tick;
   assign src_tick = src_sel ? sys_tick : slow_tick;

   generate
      if (PS_MAX == 0) begin : g_direct
         logic code_unused;
         logic active_unused;
         assign code_unused   = ^code;
         assign active_unused = active ^ clk ^ rst_n;
         assign pres_tick     = src_tick;
      end else begin : g_div
         localparam int unsigned DIV_W = PS_MAX;
         logic [DIV_W-1:0] div_q;
         logic [DIV_W:0]   one_sh;
         logic [DIV_W-1:0] lim;

         // lim = 2^code - 1; the divider restarts after every output tick
         assign one_sh    = (DIV_W+1)'(1) << code;
         assign lim       = one_sh[DIV_W-1:0] - DIV_W'(1);
         assign pres_tick = active && src_tick && (div_q == lim);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                div_q <= '0;
            else if (!active)          div_q <= '0;
            else if (pres_tick)        div_q <= '0;
            else if (src_tick)         div_q <= div_q + DIV_W'(1);
         end
      end
   endgenerate
endmodule

// File: rtl/bkl_pwm_core.sv
module bkl_pwm_core #(
   parameter int unsigned CNT_W = 8,
   parameter int unsigned PS_W  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pres_tick,
   input  logic             start_req,
   input  logic             stop_req,
   input  logic [CNT_W-1:0] cfg_cmp,
   input  logic             cfg_pol,
   input  logic [PS_W-1:0]  cfg_code,
   output logic             running,
   output logic             armed,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] act_cmp,
   output logic             act_pol,
   output logic [PS_W-1:0]  act_code,
   output logic             pwm_out
);
   localparam logic [CNT_W-1:0] LAST = '1;

   logic stop_pend;
   logic wrap;
   logic start;

   assign wrap  = running && pres_tick && (cnt == LAST);
   assign start = armed && !running && pres_tick;

   // Request bookkeeping: arming before the first tick, stop held to the boundary
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed     <= 1'b0;
         stop_pend <= 1'b0;
         running   <= 1'b0;
      end else begin
         if (start)                       armed <= 1'b0;
         else if (stop_req)               armed <= 1'b0;
         else if (start_req && !running)  armed <= 1'b1;

         if (wrap && stop_pend)           stop_pend <= 1'b0;
         else if (start_req)              stop_pend <= 1'b0;
         else if (stop_req && running)    stop_pend <= 1'b1;

         if (start)                       running <= 1'b1;
         else if (wrap && stop_pend)      running <= 1'b0;
      end
   end

   // Step counter, parked at zero while stopped
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= '0;
      else if (!running)       cnt <= '0;
      else if (pres_tick)      cnt <= cnt + CNT_W'(1);
   end

   // Working copy of the configuration: follows the store while stopped,
   // otherwise reloads only on the period boundary
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_cmp  <= '0;
         act_pol  <= 1'b0;
         act_code <= '0;
      end else if (!running || wrap) begin
         act_cmp  <= cfg_cmp;
         act_pol  <= cfg_pol;
         act_code <= cfg_code;
      end
   end

   assign pwm_out = (running && (cnt < act_cmp)) ? act_pol : !act_pol;
endmodule

// File: rtl/bkl_pwm.sv
module bkl_pwm
   import bkl_pwm_pkg::*;
#(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned CNT_W  = 8,
   parameter int unsigned PS_W   = 3,
   parameter int unsigned PS_MAX = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              slow_tick,
   input  logic              sys_tick,
   input  logic              src_sel,
   input  logic              reg_wr,
   input  logic [1:0]        reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              pwm_out
);
   generate
      if (CNT_W < 1 || CMP_LSB + CNT_W > DATA_W) begin : g_bad_cnt
         $error("bkl_pwm: compare field does not fit the data word");
      end
      if (PS_W < 1 || CODE_LSB + PS_W > POL_BIT) begin : g_bad_psw
         $error("bkl_pwm: prescaler field overlaps the polarity bit");
      end
      if (PS_MAX > (1 << PS_W) - 1) begin : g_bad_psmax
         $error("bkl_pwm: PS_MAX is not encodable in PS_W bits");
      end
   endgenerate

   logic [CNT_W-1:0] cfg_cmp;
   logic             cfg_pol;
   logic [PS_W-1:0]  cfg_code;
   logic             start_req;
   logic             stop_req;
   logic             run_w;
   logic             armed_w;
   logic             pres_tick_w;
   logic [CNT_W-1:0] cnt_w;
   logic [CNT_W-1:0] act_cmp_w;
   logic             act_pol_w;
   logic [PS_W-1:0]  act_code_w;

   bkl_pwm_regs #(
      .DATA_W (DATA_W),
      .CNT_W  (CNT_W),
      .PS_W   (PS_W),
      .PS_MAX (PS_MAX)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr        (reg_wr),
      .addr      (reg_addr),
      .wdata     (reg_wdata),
      .run_i     (run_w),
      .cfg_cmp   (cfg_cmp),
      .cfg_pol   (cfg_pol),
      .cfg_code  (cfg_code),
      .start_req (start_req),
      .stop_req  (stop_req),
      .rdata     (reg_rdata)
   );

   bkl_pwm_prescale #(
      .PS_W   (PS_W),
      .PS_MAX (PS_MAX)
   ) u_pre (
      .clk       (clk),
      .rst_n     (rst_n),
      .slow_tick (slow_tick),
      .sys_tick  (sys_tick),
      .src_sel   (src_sel),
      .active    (armed_w || run_w),
      .code      (act_code_w),
      .pres_tick (pres_tick_w)
   );

   bkl_pwm_core #(
      .CNT_W (CNT_W),
      .PS_W  (PS_W)
   ) u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .pres_tick (pres_tick_w),
      .start_req (start_req),
      .stop_req  (stop_req),
      .cfg_cmp   (cfg_cmp),
      .cfg_pol   (cfg_pol),
      .cfg_code  (cfg_code),
      .running   (run_w),
      .armed     (armed_w),
      .cnt       (cnt_w),
      .act_cmp   (act_cmp_w),
      .act_pol   (act_pol_w),
      .act_code  (act_code_w),
      .pwm_out   (pwm_out)
   );
endmodule

// File: rtl/bkl_pwm_chk.sv
module bkl_pwm_chk #(
   parameter int unsigned CNT_W  = 8,
   parameter int unsigned PS_W   = 3,
   parameter int unsigned PS_MAX = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             running,
   input logic             armed,
   input logic             pres_tick,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] act_cmp,
   input logic             act_pol,
   input logic [PS_W-1:0]  cfg_code,
   input logic             pwm_out
);
   localparam logic [CNT_W-1:0] LAST = '1;

   assert_code_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_code <= PS_W'(PS_MAX));

   assert_zero_cmp_inactive_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (running && act_cmp == '0) |-> (pwm_out == !act_pol));

   assert_start_on_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(running) |-> ($past(pres_tick) && $past(armed)));

   assert_stop_at_boundary_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(running) |-> ($past(pres_tick) && $past(cnt) == LAST));

   assert_cfg_held_in_period_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (running && !(pres_tick && cnt == LAST)) |=> ($stable(act_cmp) && $stable(act_pol)));

   assert_idle_counter_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !running |-> (cnt == '0));
endmodule

bind bkl_pwm bkl_pwm_chk #(
   .CNT_W  (CNT_W),
   .PS_W   (PS_W),
   .PS_MAX (PS_MAX)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .running   (run_w),
   .armed     (armed_w),
   .pres_tick (pres_tick_w),
   .cnt       (cnt_w),
   .act_cmp   (act_cmp_w),
   .act_pol   (act_pol_w),
   .cfg_code  (cfg_code),
   .pwm_out   (pwm_out)
);

// File: tb/bkl_pwm_bench.sv
`timescale 1ns/1ps
module bkl_pwm_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        slow_tick = 1'b0;
   logic        sys_tick = 1'b1;
   logic        src_sel = 1'b1;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_addr = 2'd3;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        pwm_out;

   int n_run = 0;
   int n_fail = 0;
   int slow_div = 0;

   always #2 clk = ~clk;

   // slow source: one tick every third cycle
   always @(negedge clk) begin
      if (slow_div == 2) begin
         slow_div = 0;
         slow_tick = 1'b1;
      end else begin
         slow_div = slow_div + 1;
         slow_tick = 1'b0;
      end
   end

   bkl_pwm u_bkl_pwm (
      .clk       (clk),
      .rst_n     (rst_n),
      .slow_tick (slow_tick),
      .sys_tick  (sys_tick),
      .src_sel   (src_sel),
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .pwm_out   (pwm_out)
   );

   function automatic logic [15:0] mk(input logic [7:0] cmp, input logic pol, input logic [2:0] code);
      return {cmp, 3'b000, pol, 1'b0, code};
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [1:0] a, input logic [15:0] d);
      reg_wr = 1'b1;
      reg_addr = a;
      reg_wdata = d;
      @(posedge clk);
      @(negedge clk);
      reg_wr = 1'b0;
      reg_addr = 2'd3;
   endtask

   task automatic rd_reg(input logic [1:0] a, output logic [15:0] d);
      reg_addr = a;
      #0.5;
      d = reg_rdata;
      reg_addr = 2'd3;
   endtask

   task automatic wait_run(input string req);
      logic [15:0] s;
      bit seen = 0;
      for (int i = 0; i < 5000 && !seen; i++) begin
         rd_reg(2'd3, s);
         if (s[0]) seen = 1;
         else @(negedge clk);
      end
      if (!seen) chk(req, 0, 1);
   endtask

   task automatic go_stop(input string req);
      logic [15:0] s;
      bit gone = 0;
      wr_reg(2'd2, 16'h0001);
      for (int i = 0; i < 20000 && !gone; i++) begin
         rd_reg(2'd3, s);
         if (!s[0]) gone = 1;
         else @(negedge clk);
      end
      if (!gone) chk(req, 1, 0);
   endtask

   // Counts cycles at the active level over n samples; optionally writes cfg at sample k
   task automatic measure(input int n, input logic pol, input bit do_wr, input int k,
                          input logic [15:0] d, output int act);
      act = 0;
      for (int i = 0; i < n; i++) begin
         if (pwm_out === pol) act++;
         if (do_wr && i == k) begin
            reg_wr = 1'b1;
            reg_addr = 2'd0;
            reg_wdata = d;
         end else if (do_wr && i == k + 1) begin
            reg_wr = 1'b0;
            reg_addr = 2'd3;
         end
         @(negedge clk);
      end
   endtask

   task automatic t_reset();
      logic [15:0] d;
      rd_reg(2'd3, d); chk("R12 status after reset", d, 0);
      rd_reg(2'd0, d); chk("R12 cfg after reset", d, 0);
      chk("R12 output after reset", pwm_out, 1);
   endtask

   task automatic t_fields();
      logic [15:0] d;
      wr_reg(2'd0, 16'hA5FB);
      rd_reg(2'd0, d); chk("R1 cfg fields readback", d, 16'hA513);
      wr_reg(2'd0, mk(8'h33, 1'b0, 3'd7));
      rd_reg(2'd0, d); chk("R2 code 7 rejected", d, 16'hA513);
   endtask

   task automatic t_idle_level();
      wr_reg(2'd0, mk(8'd50, 1'b1, 3'd0));
      @(negedge clk);
      chk("R11 idle level pol=1", pwm_out, 0);
      wr_reg(2'd0, mk(8'd50, 1'b0, 3'd0));
      @(negedge clk);
      chk("R11 idle level pol=0", pwm_out, 1);
   endtask

   task automatic t_zero_start();
      logic [15:0] d;
      wr_reg(2'd1, 16'h0000);
      repeat (20) @(negedge clk);
      rd_reg(2'd3, d); chk("R9 start write of 0 ignored", d, 0);
      chk("R9 output stays inactive", pwm_out, 1);
   endtask

   task automatic t_duty(input string req, input logic [15:0] cfg, input logic sel,
                         input int win, input int exp);
      int a;
      src_sel = sel;
      wr_reg(2'd0, cfg);
      wr_reg(2'd1, 16'h0001);
      wait_run(req);
      measure(win, cfg[4], 1'b0, 0, 16'h0, a);
      chk(req, a, exp);
      go_stop(req);
      src_sel = 1'b1;
   endtask

   task automatic t_start_timing();
      logic [15:0] d;
      wr_reg(2'd0, mk(8'd10, 1'b1, 3'd2));
      wr_reg(2'd1, 16'h0001);
      rd_reg(2'd3, d); chk("R7 status low right after start write", d, 0);
      repeat (3) @(negedge clk);
      rd_reg(2'd3, d); chk("R7 status low before first prescaled tick", d, 0);
      @(negedge clk);
      rd_reg(2'd3, d); chk("R7 status high on first prescaled tick", d, 1);
      go_stop("R7 stop");
   endtask

   task automatic t_stop_timing();
      logic [15:0] d;
      wr_reg(2'd0, mk(8'd10, 1'b1, 3'd0));
      wr_reg(2'd1, 16'h0001);
      wait_run("R8 start");
      wr_reg(2'd2, 16'h0001);
      repeat (254) @(negedge clk);
      rd_reg(2'd3, d); chk("R8 status held in last step", d, 1);
      @(negedge clk);
      rd_reg(2'd3, d); chk("R8 status low after period end", d, 0);
      chk("R8 output inactive after stop", pwm_out, 0);
   endtask

   task automatic t_zero_stop();
      logic [15:0] d;
      wr_reg(2'd0, mk(8'd10, 1'b1, 3'd0));
      wr_reg(2'd1, 16'h0001);
      wait_run("R9 start");
      wr_reg(2'd2, 16'h0000);
      repeat (600) @(negedge clk);
      rd_reg(2'd3, d); chk("R9 stop write of 0 ignored", d, 1);
      go_stop("R9 stop");
   endtask

   task automatic t_shadow();
      int a;
      wr_reg(2'd0, mk(8'd64, 1'b1, 3'd0));
      wr_reg(2'd1, 16'h0001);
      wait_run("R10 start");
      measure(256, 1'b1, 1'b1, 10, mk(8'd200, 1'b1, 3'd0), a);
      chk("R10 old compare kept in current period", a, 64);
      measure(256, 1'b1, 1'b0, 0, 16'h0, a);
      chk("R10 new compare from next period", a, 200);
      go_stop("R10 stop");
   endtask

   initial begin
      #(4 * 150000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_fields();
      t_idle_level();
      t_zero_start();
      t_duty("R3 R5 code0 cmp64 active high", mk(8'd64, 1'b1, 3'd0), 1'b1, 256, 64);
      t_duty("R3 R5 code1 cmp128 active low", mk(8'd128, 1'b0, 3'd1), 1'b1, 512, 256);
      t_duty("R3 code2 cmp3", mk(8'd3, 1'b1, 3'd2), 1'b1, 1024, 12);
      t_duty("R6 cmp0 never active", mk(8'd0, 1'b1, 3'd0), 1'b1, 256, 0);
      t_duty("R6 cmp255 active 255 of 256", mk(8'd255, 1'b1, 3'd0), 1'b1, 256, 255);
      t_duty("R4 slow source selected", mk(8'd100, 1'b1, 3'd0), 1'b0, 768, 300);
      t_start_timing();
      t_stop_timing();
      t_zero_stop();
      t_shadow();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule